// File: doc/BRIEF.md
# Triple-Redundant Register Bank with Fault Injection

This block is a register stage hardened against single upsets. Each logical bit is held in three replica flip-flops. The three replicas always load the same next value. A bitwise majority voter resolves the three replicas into the data output, and a per-bit flag reports any bit whose replicas disagree.

A test port emulates a radiation hit. When it is enabled, it names one replica and one bit position. A decoder turns that request into a flip mask with at most one bit set, so at most one stored bit in the whole bank inverts at a given clock edge. The voted output hides that single corruption. The mismatch flag shows where the corruption sits.

The block has no scrubbing of its own. A corrupted replica stays wrong until the next load rewrites all three replicas. Reset is synchronous and clears all three replicas together. The clock and reset are shared by the replicas and are not triplicated.

Top module: `tmr_reg_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three replicas become zero and any injection request is ignored. After that edge `dout` and `mismatch` both read 0.
- R2: With `rst` low and no injection, a high `load_en` copies `din` into all three replicas, so `dout` equals `din` after the edge. A low `load_en` keeps every replica unchanged.
- R3: With `inj_en` high, `inj_rep` in 0..2 and `inj_bit` below `WIDTH`, exactly one stored bit changes against the value that would otherwise be stored: bit `inj_bit` of replica `inj_rep`. The value that would otherwise be stored is `din` when loading and the held value when not loading.
- R4: While no bit has more than one replica out of agreement, `dout` equals the value of a single plain register fed by the same `din`, `load_en` and `rst`.
- R5: `mismatch[i]` is 1 exactly when the three replicas of bit i are not all equal.
- R6: An injection naming replica index 3, or a bit index of `WIDTH` or above, changes no replica.
- R7: With `inj_en` low, no replica toggles, whatever `inj_rep` and `inj_bit` hold.
- R8: While holding, a second injection into the same replica and bit restores agreement, and `mismatch` returns to 0 for that bit.
- R9: While holding, if two different replicas of the same bit have each been flipped by one injection, the voted bit of `dout` takes the inverted value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all replicas |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load `din` into all replicas |
| din | input | WIDTH | Data to store |
| inj_en | input | 1 | Request an emulated upset at this edge |
| inj_rep | input | 2 | Replica to hit: 0, 1 or 2 (3 has no effect) |
| inj_bit | input | IDX_W | Bit position to hit |
| dout | output | WIDTH | Majority-voted stored value |
| mismatch | output | WIDTH | Per-bit replica disagreement flag |

## Verification
The assertions describe replica contents from one clock edge to the next. They assume that `rst`, `load_en`, `inj_en` and `inj_rep` are never unknown at a clock edge. The bench keeps to that by driving every input to a defined value before reset is released, and it changes inputs only one nanosecond after an edge.

The stated masking of `dout` holds only while each bit has at most one corrupted replica. The random phase therefore loads on every cycle, so each fault is overwritten at the next edge and at most one corrupted replica exists at any time. Faults are allowed to accumulate only in directed tasks whose expected outcome is computed by hand.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NREP = 3;

    typedef enum logic [1:0] {
        REP_A    = 2'd0,
        REP_B    = 2'd1,
        REP_C    = 2'd2,
        REP_NONE = 2'd3
    } rep_sel_e;
endpackage

// File: rtl/tmr_inject_dec.sv
module tmr_inject_dec
    import tmr_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  logic                       inj_en,
    input  logic [1:0]                 inj_rep,
    input  logic [IDX_W-1:0]           inj_bit,
    output logic [NREP-1:0][WIDTH-1:0] flip
);
    // One comparator per (replica, bit) cell: an index outside the grid hits no cell.
    for (genvar r = 0; r < NREP; r++) begin : g_rep
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign flip[r][b] = inj_en
                             && (inj_rep == 2'(r))
                             && (inj_bit == IDX_W'(b));
        end
    end

    // R3: at most one cell of the mask is ever set.
    always_comb begin
        p_one_hit_r3: assert ($onehot0(flip) || $isunknown({inj_en, inj_rep, inj_bit}))
            else $error("injection mask sets more than one bit");
    end
endmodule

// File: rtl/tmr_replica.sv
module tmr_replica #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] flip,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    // The emulated upset inverts the value about to be stored.
    always_comb begin
        nxt = (load_en ? din : q) ^ flip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] mm
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_vote
        assign y[i]  = (a[i] & b[i]) | (b[i] & c[i]) | (a[i] & c[i]);
        assign mm[i] = (a[i] ^ b[i]) | (b[i] ^ c[i]);
    end
endmodule

// File: rtl/tmr_reg_bank.sv
module tmr_reg_bank
    import tmr_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] din,
    input  logic             inj_en,
    input  logic [1:0]       inj_rep,
    input  logic [IDX_W-1:0] inj_bit,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] mismatch
);
    logic [NREP-1:0][WIDTH-1:0] flip;
    logic [NREP-1:0][WIDTH-1:0] rep_q;

    tmr_inject_dec #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_dec (
        .inj_en  (inj_en),
        .inj_rep (inj_rep),
        .inj_bit (inj_bit),
        .flip    (flip)
    );

    for (genvar r = 0; r < NREP; r++) begin : g_copy
        tmr_replica #(.WIDTH(WIDTH)) u_rep (
            .clk     (clk),
            .rst     (rst),
            .load_en (load_en),
            .din     (din),
            .flip    (flip[r]),
            .q       (rep_q[r])
        );
    end

    tmr_voter #(.WIDTH(WIDTH)) u_vote (
        .a  (rep_q[REP_A]),
        .b  (rep_q[REP_B]),
        .c  (rep_q[REP_C]),
        .y  (dout),
        .mm (mismatch)
    );

    // R1: a reset edge leaves all replicas cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rep_q == '0))
        else $error("replicas not cleared by reset");

    // R2: a clean load copies din into every replica.
    p_load_copy_r2: assert property (@(posedge clk) disable iff (rst)
        (load_en && !inj_en) |=>
            (rep_q[REP_A] == $past(din)) && (rep_q[REP_B] == $past(din))
            && (rep_q[REP_C] == $past(din)))
        else $error("clean load did not reach all replicas");

    // R2, R7: with no load and no request, nothing moves.
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !inj_en) |=> $stable(rep_q))
        else $error("replica toggled with no injection");

    // R3: while holding, at most one stored bit changes per edge.
    p_single_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ($countones(rep_q ^ $past(rep_q)) <= 1))
        else $error("more than one replica bit toggled");

    // R6: an out-of-range replica index hits nothing.
    p_bad_index_r6: assert property (@(posedge clk) disable iff (rst)
        (!load_en && inj_en && (inj_rep == REP_NONE)) |=> $stable(rep_q))
        else $error("replica index 3 changed state");
endmodule

// File: tb/tmr_reg_bank_test.sv
module tmr_reg_bank_test;
    localparam int W  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_en;
    logic [W-1:0]  din;
    logic          inj_en;
    logic [1:0]    inj_rep;
    logic [IW-1:0] inj_bit;
    logic [W-1:0]  dout;
    logic [W-1:0]  mismatch;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tmr_reg_bank #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .din      (din),
        .inj_en   (inj_en),
        .inj_rep  (inj_rep),
        .inj_bit  (inj_bit),
        .dout     (dout),
        .mismatch (mismatch)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive inputs, wait for one edge, then settle 1 ns past it.
    task automatic step(input logic l, input logic [W-1:0] d, input logic ie,
                        input logic [1:0] rp, input logic [IW-1:0] bt);
        load_en = l; din = d; inj_en = ie; inj_rep = rp; inj_bit = bt;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(1'b1, 8'hFF, 1'b1, 2'd0, 3'd0);
        step(1'b1, 8'hFF, 1'b1, 2'd1, 3'd5);
        check("R1 dout after reset", dout, 8'h00);
        check("R1 mismatch after reset", mismatch, 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_load_hold;
        step(1'b1, 8'hA5, 1'b0, 2'd0, 3'd0);
        check("R2 load", dout, 8'hA5);
        step(1'b0, 8'h3C, 1'b0, 2'd0, 3'd0);
        check("R2 hold", dout, 8'hA5);
    endtask

    task automatic t_no_request;
        step(1'b0, 8'h00, 1'b0, 2'd2, 3'd6);
        check("R7 mismatch idle", mismatch, 8'h00);
        check("R7 dout idle", dout, 8'hA5);
    endtask

    task automatic t_single_then_undo;
        step(1'b0, 8'h00, 1'b1, 2'd1, 3'd2);
        check("R4 dout masked", dout, 8'hA5);
        check("R5 mismatch one bit", mismatch, 8'h04);
        step(1'b0, 8'h00, 1'b1, 2'd1, 3'd2);
        check("R8 mismatch cleared", mismatch, 8'h00);
        check("R8 dout", dout, 8'hA5);
    endtask

    task automatic t_bad_index;
        step(1'b0, 8'h00, 1'b1, 2'd3, 3'd1);
        check("R6 mismatch", mismatch, 8'h00);
        check("R6 dout", dout, 8'hA5);
    endtask

    task automatic t_inject_on_load;
        step(1'b1, 8'h0F, 1'b1, 2'd0, 3'd7);
        check("R3 dout on load", dout, 8'h0F);
        check("R3 mismatch on load", mismatch, 8'h80);
        step(1'b1, 8'h0F, 1'b0, 2'd0, 3'd0);
        check("R2 reload clears fault", mismatch, 8'h00);
    endtask

    task automatic t_double_hit;
        step(1'b0, 8'h00, 1'b1, 2'd0, 3'd0);
        check("R4 first hit masked", dout, 8'h0F);
        step(1'b0, 8'h00, 1'b1, 2'd2, 3'd0);
        check("R9 outvoted", dout, 8'h0E);
        check("R5 minority flagged", mismatch, 8'h01);
    endtask

    task automatic t_random;
        logic [W-1:0] ref_q;
        logic [W-1:0] exp_mm;
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0]  d;
            logic          ie;
            logic [1:0]    rp;
            logic [IW-1:0] bt;
            d  = W'($urandom);
            ie = 1'($urandom);
            rp = 2'($urandom_range(2, 0));
            bt = IW'($urandom);
            step(1'b1, d, ie, rp, bt);
            ref_q  = d;
            exp_mm = ie ? (W'(1) << bt) : '0;
            check("R4 random vote", dout, ref_q);
            check("R5 random mismatch", mismatch, exp_mm);
        end
    endtask

    initial begin
        rst = 1'b1; load_en = 1'b0; din = '0;
        inj_en = 1'b0; inj_rep = '0; inj_bit = '0;
        #1;
        t_reset();
        t_load_hold();
        t_no_request();
        t_single_then_undo();
        t_bad_index();
        t_inject_on_load();
        t_double_hit();
        t_random();
        t_reset();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule